// File: doc/BRIEF.md
# Local-History Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken by looking at how that same branch behaved on its own recent executions. A first table, selected by a slice of the branch address, keeps a short shift register of recent outcomes for every branch slot. That history pattern, and nothing else, selects one 2-bit saturating counter in a second table, and the counter's upper half means "taken". Both tables are read combinationally from the fetch address in the same cycle.

The fetch side returns the predicted direction together with the history pattern and the counter value that produced it. The pipeline carries both values alongside the instruction. When the branch resolves, the pipeline hands them back with the real outcome on the update side. The block then shifts the outcome into the carried history and writes it to the branch's slot. In the same cycle it steps the carried counter toward the outcome and writes it back to the entry the carried history selects. Target prediction and misprediction recovery belong to other blocks.

Top module: `lhp_local_predictor`

## Requirements
- R1: While reset is asserted and after it is released, every history slot reads 0 and every counter reads 1, so any fetch address returns history 0, counter 1 and a not-taken prediction.
- R2: The history slot is selected only by address bits [IDX_LSB+IDX_W-1:IDX_LSB], which are bits 9:2 by default. Addresses that differ only in bits outside that field read and write the same slot.
- R3: The prediction is taken (1) exactly when the counter read at fetch is 2 or 3, and not taken (0) when it is 0 or 1.
- R4: A qualifying update writes {u_hist[HIST_W-2:0], u_taken} into the slot that u_pc selects. The oldest history bit is dropped, and a taken outcome enters as a 1 in bit 0.
- R5: A qualifying update writes the carried counter plus one to the counter entry that u_hist selects when u_taken is 1, stopping at 3. When u_taken is 0 it writes the carried counter minus one, stopping at 0.
- R6: An update changes neither table unless u_valid and u_is_branch are both 1.
- R7: A fetch that reads an entry in the same cycle as an update writes it returns the contents from before the write. The written value is seen from the next cycle on.
- R8: The counter table is indexed only by the history pattern, so two different branches whose slots hold the same history share one counter.
- R9: The counter written at update is derived from the carried u_ctr, not from what the table holds at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| f_pc | input | PC_W | Address of the instruction being fetched |
| f_pred_taken | output | 1 | Predicted direction, 1 = taken |
| f_hist | output | HIST_W | History pattern read for f_pc, to be carried with the instruction |
| f_ctr | output | 2 | Counter value that produced the prediction, to be carried with the instruction |
| u_valid | input | 1 | A resolved instruction is presented on the update side |
| u_is_branch | input | 1 | The resolved instruction is a conditional branch |
| u_pc | input | PC_W | Address of the resolved branch |
| u_hist | input | HIST_W | History pattern carried from fetch |
| u_ctr | input | 2 | Counter value carried from fetch |
| u_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench drives fetch and update in the same cycle on one slot. A design that forwarded the new value instead of returning the stored one would show the updated history too early. It steps counters past both ends. A wrapping counter would turn a strong taken into a strong not-taken, or the reverse, and the bench catches this through the counter read back next. It hands in a carried counter that differs from the table's own value, which exposes a design that re-reads the table at update. It also aliases addresses through the ignored low and high bits, which catches an off-by-one index slice. Updates with only one of the two qualifiers set must leave both tables untouched. Reset is re-applied mid-run to confirm that both tables return to their initial values at once.

// File: rtl/lhp_pkg.sv
package lhp_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_RESET = 2'd1;   // weakly not taken
  localparam ctr_t CTR_MAX   = 2'd3;
  localparam ctr_t CTR_MIN   = 2'd0;
  localparam ctr_t CTR_TAKEN = 2'd2;   // lowest value predicting taken
endpackage

// File: rtl/lhp_sat_ctr.sv
module lhp_sat_ctr
  import lhp_pkg::*;
(
  input  logic [CTR_W-1:0] cur,
  input  logic             up,
  output logic [CTR_W-1:0] nxt
);
  always_comb begin
    nxt = cur;
    if (up) begin
      if (cur != CTR_MAX) nxt = cur + 1'b1;
    end else begin
      if (cur != CTR_MIN) nxt = cur - 1'b1;
    end
  end
endmodule

// File: rtl/lhp_hist_shift.sv
module lhp_hist_shift #(
  parameter int HIST_W = 8
) (
  input  logic [HIST_W-1:0] hist,
  input  logic              taken,
  output logic [HIST_W-1:0] nxt
);
  // newest outcome enters at bit 0, oldest leaves from the top
  assign nxt = {hist[HIST_W-2:0], taken};
endmodule

// File: rtl/lhp_entry_array.sv
module lhp_entry_array #(
  parameter int            AW      = 8,
  parameter int            DW      = 8,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic [DEPTH-1:0]         ent_we;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DW-1:0] ent_q;
    logic [DW-1:0] ent_d;

    assign ent_we[g] = wr_en && (wr_idx == AW'(g));

    always_comb begin
      ent_d = ent_q;
      if (ent_we[g]) ent_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ent_q <= RST_VAL;
      else if (ent_we[g]) ent_q <= ent_d;
    end

    assign mem_q[g] = ent_q;
  end

  // read sees stored contents; a same-cycle write lands at the edge
  assign rd_data = mem_q[rd_idx];

  AST_WRITE_VISIBLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_idx)] == $past(wr_data)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q)); // R6
endmodule

// File: rtl/lhp_local_predictor.sv
module lhp_local_predictor
  import lhp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 8,
  parameter int HIST_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   f_pc,
  output logic              f_pred_taken,
  output logic [HIST_W-1:0] f_hist,
  output logic [1:0]        f_ctr,
  input  logic              u_valid,
  input  logic              u_is_branch,
  input  logic [PC_W-1:0]   u_pc,
  input  logic [HIST_W-1:0] u_hist,
  input  logic [1:0]        u_ctr,
  input  logic              u_taken
);
  localparam int IDX_HI = IDX_LSB + IDX_W;

  // reset: asserts at once, releases on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [IDX_W-1:0]  f_idx, u_idx;
  logic [HIST_W-1:0] bht_wdata;
  ctr_t              pht_wdata;
  ctr_t              pht_rdata;
  logic              upd;
  logic              unused_pc_bits;

  assign f_idx = f_pc[IDX_HI-1:IDX_LSB];
  assign u_idx = u_pc[IDX_HI-1:IDX_LSB];
  assign unused_pc_bits = ^{f_pc[PC_W-1:IDX_HI], f_pc[IDX_LSB-1:0],
                            u_pc[PC_W-1:IDX_HI], u_pc[IDX_LSB-1:0]};
  assign upd = u_valid && u_is_branch;

  lhp_hist_shift #(.HIST_W(HIST_W)) u_shift (
    .hist  (u_hist),
    .taken (u_taken),
    .nxt   (bht_wdata)
  );

  lhp_sat_ctr u_step (
    .cur (u_ctr),
    .up  (u_taken),
    .nxt (pht_wdata)
  );

  // first level: per-branch history, addressed by the address slice
  lhp_entry_array #(.AW(IDX_W), .DW(HIST_W), .RST_VAL('0)) u_bht (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .rd_idx  (f_idx),
    .rd_data (f_hist),
    .wr_en   (upd),
    .wr_idx  (u_idx),
    .wr_data (bht_wdata)
  );

  // second level: counters, addressed by the history pattern alone
  lhp_entry_array #(.AW(HIST_W), .DW(CTR_W), .RST_VAL(CTR_RESET)) u_pht (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .rd_idx  (f_hist),
    .rd_data (pht_rdata),
    .wr_en   (upd),
    .wr_idx  (u_hist),
    .wr_data (pht_wdata)
  );

  assign f_ctr        = pht_rdata;
  assign f_pred_taken = (pht_rdata >= CTR_TAKEN);

  AST_HIST_APPENDS_OUTCOME: assert property (@(posedge clk) disable iff (!rst_sync_q)
    upd |-> (bht_wdata[0] == u_taken) && (bht_wdata[HIST_W-1:1] == u_hist[HIST_W-2:0])); // R4

  AST_CTR_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (upd && u_taken) |-> (pht_wdata >= u_ctr)); // R5

  AST_CTR_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (upd && !u_taken) |-> (pht_wdata <= u_ctr)); // R5

  AST_CTR_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_sync_q)
    upd |-> ($countones(pht_wdata ^ u_ctr) <= 2) && (pht_wdata != u_ctr || u_ctr == CTR_MAX || u_ctr == CTR_MIN)); // R9
endmodule

// File: tb/lhp_local_predictor_bench.sv
`timescale 1ns/1ps
module lhp_local_predictor_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] f_pc;
  logic        f_pred_taken;
  logic [7:0]  f_hist;
  logic [1:0]  f_ctr;
  logic        u_valid, u_is_branch, u_taken;
  logic [31:0] u_pc;
  logic [7:0]  u_hist;
  logic [1:0]  u_ctr;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  lhp_local_predictor u_lhp_local_predictor (
    .clk, .rst_n, .f_pc, .f_pred_taken, .f_hist, .f_ctr,
    .u_valid, .u_is_branch, .u_pc, .u_hist, .u_ctr, .u_taken
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  typedef struct packed {
    logic        uv;
    logic        ub;
    logic [31:0] upc;
    logic [7:0]  uh;
    logic [1:0]  uc;
    logic        ut;
    logic [31:0] fpc;
    logic [7:0]  eh;
    logic [1:0]  ec;
    logic        ep;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,32'h0,  8'h00,2'd0,1'b0, 32'h100, 8'h00,2'd1,1'b0, 8'd1}, // R1 initial state
    '{1'b1,1'b1,32'h100,8'h00,2'd1,1'b1, 32'h100, 8'h00,2'd1,1'b0, 8'd7}, // R7 read before write
    '{1'b0,1'b0,32'h0,  8'h00,2'd0,1'b0, 32'h100, 8'h01,2'd1,1'b0, 8'd4}, // R4 outcome shifted in
    '{1'b0,1'b0,32'h0,  8'h00,2'd0,1'b0, 32'h200, 8'h00,2'd2,1'b1, 8'd8}, // R8 shared counter, R3
    '{1'b1,1'b1,32'h100,8'h01,2'd1,1'b1, 32'h102, 8'h01,2'd1,1'b0, 8'd2}, // R2 low bits ignored
    '{1'b0,1'b0,32'h0,  8'h00,2'd0,1'b0, 32'h503, 8'h03,2'd1,1'b0, 8'd2}, // R2 high bits alias
    '{1'b1,1'b0,32'h100,8'h03,2'd3,1'b1, 32'h100, 8'h03,2'd1,1'b0, 8'd6}, // R6 not a branch
    '{1'b0,1'b1,32'h100,8'h03,2'd3,1'b0, 32'h100, 8'h03,2'd1,1'b0, 8'd6}, // R6 not valid
    '{1'b0,1'b0,32'h0,  8'h00,2'd0,1'b0, 32'h100, 8'h03,2'd1,1'b0, 8'd6}, // R6 both tables held
    '{1'b1,1'b1,32'h300,8'h80,2'd3,1'b1, 32'h300, 8'h00,2'd2,1'b1, 8'd3}, // R3 counter 2 taken
    '{1'b0,1'b0,32'h0,  8'h00,2'd0,1'b0, 32'h300, 8'h01,2'd2,1'b1, 8'd4}, // R4 oldest bit dropped
    '{1'b1,1'b1,32'h400,8'hFF,2'd0,1'b0, 32'h400, 8'h00,2'd2,1'b1, 8'd5}, // R5 floor step
    '{1'b1,1'b1,32'h404,8'h7F,2'd3,1'b0, 32'h400, 8'hFE,2'd1,1'b0, 8'd4}, // R4 not-taken enters 0
    '{1'b1,1'b1,32'h408,8'h7F,2'd2,1'b1, 32'h404, 8'hFE,2'd1,1'b0, 8'd4}, // R4
    '{1'b0,1'b0,32'h0,  8'h00,2'd0,1'b0, 32'h408, 8'hFF,2'd0,1'b0, 8'd5}, // R5 stays at 0
    '{1'b1,1'b1,32'h40C,8'hFF,2'd2,1'b0, 32'h408, 8'hFF,2'd0,1'b0, 8'd7}, // R7 same counter entry
    '{1'b0,1'b0,32'h0,  8'h00,2'd0,1'b0, 32'h408, 8'hFF,2'd1,1'b0, 8'd9}, // R9 carried counter used
    '{1'b1,1'b1,32'h410,8'hC0,2'd3,1'b0, 32'h410, 8'h00,2'd2,1'b1, 8'd3}, // R3
    '{1'b0,1'b0,32'h0,  8'h00,2'd0,1'b0, 32'h410, 8'h80,2'd3,1'b1, 8'd5}, // R5 stays at 3
    '{1'b0,1'b0,32'h0,  8'h00,2'd0,1'b0, 32'h40C, 8'hFE,2'd1,1'b0, 8'd4}  // R4
  };

  task automatic chk(input int rq, input logic [7:0] eh, input logic [1:0] ec, input logic ep);
    n_checks++;
    if (f_hist !== eh || f_ctr !== ec || f_pred_taken !== ep) begin
      n_fail++;
      $display("FAIL R%0d: hist=%h ctr=%0d pred=%b expected hist=%h ctr=%0d pred=%b",
               rq, f_hist, f_ctr, f_pred_taken, eh, ec, ep);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=expired expected=complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; f_pc = '0; u_valid = 0; u_is_branch = 0;
    u_pc = '0; u_hist = '0; u_ctr = '0; u_taken = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      u_valid = VECS[i].uv; u_is_branch = VECS[i].ub; u_pc = VECS[i].upc;
      u_hist = VECS[i].uh; u_ctr = VECS[i].uc; u_taken = VECS[i].ut;
      f_pc = VECS[i].fpc;
      #1;
      chk(int'(VECS[i].req), VECS[i].eh, VECS[i].ec, VECS[i].ep);
      @(negedge clk);
    end

    // R1: reset in the middle of a run clears both tables at once
    u_valid = 0; u_is_branch = 0;
    f_pc = 32'h410;
    rst_n = 1'b0;
    #1;
    chk(1, 8'h00, 2'd1, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    f_pc = 32'h408;
    #1;
    chk(1, 8'h00, 2'd1, 1'b0);

    // R3: one taken update lifts counter 0 from 1 to 2, prediction flips
    u_valid = 1; u_is_branch = 1; u_pc = 32'h100; u_hist = 8'h00; u_ctr = 2'd1; u_taken = 1;
    @(negedge clk);
    u_valid = 0; u_is_branch = 0;
    f_pc = 32'h200;
    #1;
    chk(3, 8'h00, 2'd2, 1'b1);

    @(negedge clk);
    finish_run();
  end
endmodule